// File: doc/BRIEF.md
# Multi-channel interval timer

This block holds six independent 32-bit down-counters behind a small word-wide register window. Each counter is started, stopped and reconfigured through its own control word. It decrements on pulses from one of four clock-source tick inputs. A power-of-two prescaler sits between the selected tick and the decrement, so one counter can run at a fraction of its source rate.

A counter that reaches its end raises a bit in a shared status register. It then either reloads itself and runs again, or stops and drops its own enable bit. A shared enable mask decides which status bits reach the six interrupt outputs, and software clears status bits by writing ones to them. The window is 0x400 bytes wide. Register reads are combinational from the address, and writes take effect on the rising clock edge while the write strobe is high. Only word-aligned addresses (address bits [1:0] zero) hit a register.

Top module: `pit_bank`

## Requirements
- R1: Interrupt output i is high exactly when status bit i and mask bit i are both 1. The mask register is at offset 0x00 and holds bits [5:0]. Its upper bits read as zero.
- R2: The status register is at offset 0x04. A write to it clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R3: Timer n (n = 0..5) has control at 0x10+0x10*n, interval at +0x4 and count at +0x8, all readable. Writing the count word loads the counter directly.
- R4: The control word layout is: bit 0 enable, bit 1 reload, bits [3:2] source select, bits [6:4] prescale exponent, bit 7 one-shot. Bits above 7 read as zero. A disabled timer, or one whose selected source never pulses, keeps its count.
- R5: An enabled timer decrements once every 2^p pulses of its selected source, where p is the prescale exponent. The prescale phase restarts on every control write, and a control write cycle does not decrement.
- R6: A control write with the reload bit set copies the interval into the count. The reload bit reads back as written.
- R7: The decrement from 1 to 0 is an expiry. It sets the timer's status bit, which stays set until software clears it. In periodic mode (bit 7 = 0) the count reloads from the interval and counting continues.
- R8: On expiry in one-shot mode (bit 7 = 1) the count stays at 0 and the hardware clears the enable bit. The other control bits are kept.
- R9: An enabled timer whose count is 0 loads the interval on its next decrement, without an expiry. A timer with interval 0 therefore never sets its status bit.
- R10: After reset the mask, the status and every interval and count are 0. Every control word is 0x04 (stopped, source 1).
- R11: Accesses to any other offset read as zero and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 10 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| src_tick | input | 4 | Clock-source tick pulses, one per source |
| irq | output | 6 | Interrupt line per timer |

## Verification
On every cycle, the checker covers these properties:
- the mask gating of the interrupt lines after a mask write;
- write-one-to-clear on the status register;
- status bits staying set when the status register is not written;
- every expiry landing in the status register;
- the hardware dropping the enable bit on a one-shot expiry;
- zero read data above the mapped range.

Some behaviours can only be shown by the bench's scenarios, because they depend on how many source pulses elapsed:
- the exact count after a known run of pulses with and without prescaling;
- the reload on a control write;
- the zero-count reload without expiry;
- a tied-off source freezing the counter.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CTRL_W   = 8;
    localparam int EN_BIT   = 0;
    localparam int RLD_BIT  = 1;
    localparam int SRC_LO   = 2;
    localparam int SRC_W    = 2;
    localparam int PSC_LO   = 4;
    localparam int PSC_W    = 3;
    localparam int MODE_BIT = 7;
    localparam int PRE_W    = (1 << PSC_W) - 1;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_INTV = 2'd1,
        FLD_CNT  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;
endpackage

// File: rtl/pit_decode.sv
module pit_decode
    import pit_pkg::*;
#(
    parameter int N_TMR = 6,
    parameter int AW    = 10
) (
    input  logic [AW-1:0]    addr,
    output logic             hit_ien,
    output logic             hit_ist,
    output logic [N_TMR-1:0] chan_hit,
    output fld_e             fld
);
    localparam int SLOT_W = AW - 4;

    logic aligned;
    logic in_block;

    assign aligned  = (addr[1:0] == 2'b00);
    assign hit_ien  = (addr == AW'(0));
    assign hit_ist  = (addr == AW'(4));
    assign in_block = aligned && (addr[3:2] != 2'd3);
    assign fld      = fld_e'(addr[3:2]);

    for (genvar i = 0; i < N_TMR; i++) begin : g_slot
        assign chan_hit[i] = in_block && (addr[AW-1:4] == SLOT_W'(i + 1));
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int              DW       = 32,
    parameter logic [CTRL_W-1:0] RST_CTRL = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_tick,
    input  logic              wr_ctrl,
    input  logic              wr_intv,
    input  logic              wr_cnt,
    input  logic [DW-1:0]     wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DW-1:0]     intv_q,
    output logic [DW-1:0]     cnt_q,
    output logic              expire
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DW-1:0]     intv;
        logic [DW-1:0]     cnt;
        logic [PRE_W-1:0]  pre;
    } ch_s;

    ch_s st_d, st_q;

    logic             tick;
    logic             step;
    logic [PRE_W:0]   lim_full;
    logic [PSC_W-1:0] psc;
    logic [SRC_W-1:0] src_sel;

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        step     = 1'b0;
        psc      = st_q.ctrl[PSC_LO +: PSC_W];
        src_sel  = st_q.ctrl[SRC_LO +: SRC_W];
        tick     = st_q.ctrl[EN_BIT] && src_tick[src_sel];
        lim_full = ((PRE_W + 1)'(1) << psc) - (PRE_W + 1)'(1);

        if (wr_ctrl) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            st_d.pre  = '0;
            if (wdata[RLD_BIT]) begin
                st_d.cnt = st_q.intv;
            end
        end else if (tick) begin
            if ({1'b0, st_q.pre} == lim_full) begin
                st_d.pre = '0;
                step     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
            if (step) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = st_q.intv;
                end else if (st_q.cnt == DW'(1)) begin
                    expire = 1'b1;
                    if (st_q.ctrl[MODE_BIT]) begin
                        st_d.cnt          = '0;
                        st_d.ctrl[EN_BIT] = 1'b0;
                    end else begin
                        st_d.cnt = st_q.intv;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - DW'(1);
                end
            end
        end

        if (wr_intv) begin
            st_d.intv = wdata;
        end
        if (wr_cnt) begin
            st_d.cnt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= RST_CTRL;
            st_q.intv <= '0;
            st_q.cnt  <= '0;
            st_q.pre  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign intv_q = st_q.intv;
    assign cnt_q  = st_q.cnt;
endmodule

// File: rtl/pit_bank.sv
module pit_bank
    import pit_pkg::*;
#(
    parameter int                N_TMR    = 6,
    parameter int                DW       = 32,
    parameter int                AW       = 10,
    parameter int                N_SRC    = 4,
    parameter logic [CTRL_W-1:0] RST_CTRL = 8'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [N_SRC-1:0] src_tick,
    output logic [N_TMR-1:0] irq
);
    typedef struct packed {
        logic [N_TMR-1:0] ien;
        logic [N_TMR-1:0] ist;
    } glb_s;

    glb_s st_d, st_q;

    logic             hit_ien;
    logic             hit_ist;
    logic [N_TMR-1:0] chan_hit;
    fld_e             fld;

    logic [N_TMR-1:0]             expire;
    logic [N_TMR-1:0][CTRL_W-1:0] ch_ctrl;
    logic [N_TMR-1:0][DW-1:0]     ch_intv;
    logic [N_TMR-1:0][DW-1:0]     ch_cnt;
    logic [N_TMR-1:0]             ien_q;
    logic [N_TMR-1:0]             ist_q;

    pit_decode #(
        .N_TMR (N_TMR),
        .AW    (AW)
    ) u_decode (
        .addr     (addr),
        .hit_ien  (hit_ien),
        .hit_ist  (hit_ist),
        .chan_hit (chan_hit),
        .fld      (fld)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_chan
        pit_channel #(
            .DW       (DW),
            .RST_CTRL (RST_CTRL)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick[3:0]),
            .wr_ctrl  (wr_en && chan_hit[i] && (fld == FLD_CTRL)),
            .wr_intv  (wr_en && chan_hit[i] && (fld == FLD_INTV)),
            .wr_cnt   (wr_en && chan_hit[i] && (fld == FLD_CNT)),
            .wdata    (wdata),
            .ctrl_q   (ch_ctrl[i]),
            .intv_q   (ch_intv[i]),
            .cnt_q    (ch_cnt[i]),
            .expire   (expire[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && hit_ien) begin
            st_d.ien = wdata[N_TMR-1:0];
        end
        if (wr_en && hit_ist) begin
            st_d.ist = st_q.ist & ~wdata[N_TMR-1:0];
        end
        st_d.ist = st_d.ist | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ien) begin
            rdata = DW'(st_q.ien);
        end
        if (hit_ist) begin
            rdata = DW'(st_q.ist);
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (chan_hit[i]) begin
                case (fld)
                    FLD_CTRL: rdata = DW'(ch_ctrl[i]);
                    FLD_INTV: rdata = ch_intv[i];
                    FLD_CNT:  rdata = ch_cnt[i];
                    default:  rdata = '0;
                endcase
            end
        end
    end

    assign ien_q = st_q.ien;
    assign ist_q = st_q.ist;
    assign irq   = st_q.ist & st_q.ien;
endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
#(
    parameter int N_TMR = 6,
    parameter int DW    = 32,
    parameter int AW    = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [AW-1:0]                addr,
    input logic [DW-1:0]                wdata,
    input logic [DW-1:0]                rdata,
    input logic [N_TMR-1:0]             irq,
    input logic [N_TMR-1:0]             ien_q,
    input logic [N_TMR-1:0]             ist_q,
    input logic [N_TMR-1:0]             expire,
    input logic [N_TMR-1:0][CTRL_W-1:0] ch_ctrl
);
    logic wr_ien;
    logic wr_ist;

    assign wr_ien = wr_en && (addr == AW'(0));
    assign wr_ist = wr_en && (addr == AW'(4));

    // R1: after a mask write, no line outside the new mask can be high
    a_r1_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> ((irq & ~$past(wdata[N_TMR-1:0])) == '0));

    // R1: a high line always has its status bit behind it
    a_r1_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~ist_q) == '0));

    // R2: bits written as 1 are gone unless an expiry landed in the same cycle
    a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ist |=> ((ist_q & $past(wdata[N_TMR-1:0] & ~expire)) == '0));

    // R7: status bits only fall through a status write
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ist |=> (($past(ist_q) & ~ist_q) == '0));

    // R7: every expiry reaches the status register
    a_r7_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((ist_q & $past(expire)) == $past(expire)));

    // R11: offsets above the last timer block read as zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= AW'(112)) |-> (rdata == '0));

    for (genvar i = 0; i < N_TMR; i++) begin : g_one
        // R8: one-shot expiry drops the enable bit
        a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && ch_ctrl[i][MODE_BIT] && !(wr_en && addr == AW'((i + 1) * 16)))
            |=> !ch_ctrl[i][EN_BIT]);
    end
endmodule

bind pit_bank pit_checker #(
    .N_TMR (N_TMR),
    .DW    (DW),
    .AW    (AW)
) u_pit_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .ien_q   (ien_q),
    .ist_q   (ist_q),
    .expire  (expire),
    .ch_ctrl (ch_ctrl)
);

// File: tb/test_pit_bank.sv
`timescale 1ns/1ps
module test_pit_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  src_tick = 4'b0010;
    logic [5:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [9:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    pit_bank i_pit_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .src_tick (src_tick),
        .irq      (irq)
    );

    function automatic logic [9:0] ta(input int n, input int off);
        return 10'((n + 1) * 16 + off);
    endfunction

    // all tasks start and end at a falling edge
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic [5:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.a = addr; it.exp = 32'(e); it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares scoreboard items just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? 32'(irq) : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
                             it.tag, it.a, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(10'h000, 32'h0, "R10 mask");
        rd(10'h004, 32'h0, "R10 status");
        rd(ta(0, 0), 32'h04, "R10 ctrl0");
        rd(ta(5, 0), 32'h04, "R10 ctrl5");
        rd(ta(0, 4), 32'h0, "R10 interval0");
        rd(ta(0, 8), 32'h0, "R10 count0");
        chk_irq(6'h00, "R10 irq");

        // R3 interval readback, R5 plain counting
        wr(ta(0, 4), 32'd100);
        rd(ta(0, 4), 32'd100, "R3 interval0");
        wr(ta(0, 0), 32'h07);
        idle(5);
        wr(ta(0, 0), 32'h04);
        rd(ta(0, 8), 32'd95, "R5 count after 5 ticks p=0");
        rd(ta(0, 0), 32'h04, "R4 ctrl readback");
        idle(3);
        rd(ta(0, 8), 32'd95, "R4 disabled holds count");

        // R5 prescale 2^2
        wr(ta(0, 0), 32'h27);
        idle(8);
        wr(ta(0, 0), 32'h24);
        rd(ta(0, 8), 32'd98, "R5 count after 8 ticks p=2");

        // R3 direct count write
        wr(ta(0, 8), 32'd7);
        rd(ta(0, 8), 32'd7, "R3 count write");

        // R6 reload without enable
        wr(ta(0, 0), 32'h06);
        rd(ta(0, 8), 32'd100, "R6 reload loads interval");
        rd(ta(0, 0), 32'h06, "R6 reload bit reads back");

        // R7 periodic expiry on timer 1
        wr(ta(1, 4), 32'd3);
        wr(ta(1, 0), 32'h07);
        idle(3);
        rd(10'h004, 32'h02, "R7 status after expiry");
        chk_irq(6'h00, "R1 masked irq low");
        wr(10'h000, 32'h02);
        chk_irq(6'h02, "R1 irq with mask");
        idle(4);
        rd(ta(1, 0), 32'h07, "R7 periodic keeps enable");
        wr(ta(1, 0), 32'h04);

        // R2 write-one-to-clear
        wr(10'h004, 32'h01);
        rd(10'h004, 32'h02, "R2 zero bit keeps status");
        wr(10'h004, 32'h02);
        rd(10'h004, 32'h00, "R2 one bit clears status");
        chk_irq(6'h00, "R2 irq after clear");

        // R8 one-shot on timer 2
        wr(ta(2, 4), 32'd4);
        wr(ta(2, 0), 32'h87);
        idle(10);
        rd(ta(2, 0), 32'h86, "R8 enable cleared");
        rd(ta(2, 8), 32'd0, "R8 count stays zero");
        rd(10'h004, 32'h04, "R8 status set");
        chk_irq(6'h00, "R1 other mask bit");
        wr(10'h000, 32'h06);
        chk_irq(6'h04, "R1 one-shot irq");

        // R9 interval zero never expires
        wr(ta(3, 0), 32'h05);
        idle(20);
        rd(10'h004, 32'h04, "R9 interval zero no status");
        // R9 zero count reloads without expiry
        wr(ta(4, 4), 32'd5);
        wr(ta(4, 0), 32'h05);
        idle(2);
        wr(ta(4, 0), 32'h04);
        rd(ta(4, 8), 32'd4, "R9 zero count reload");
        rd(10'h004, 32'h04, "R9 no expiry on reload");

        // R4 tied-off source 0
        wr(ta(5, 4), 32'd50);
        wr(ta(5, 0), 32'h03);
        idle(10);
        rd(ta(5, 8), 32'd50, "R4 tied source holds");

        // R11 unmapped
        wr(ta(0, 12), 32'hFFFF_FFFF);
        rd(ta(0, 12), 32'h0, "R11 gap word reads zero");
        wr(10'h3FC, 32'hFFFF_FFFF);
        wr(10'h002, 32'hFFFF_FFFF);
        rd(10'h080, 32'h0, "R11 high offset reads zero");
        rd(10'h000, 32'h06, "R11 mask untouched");
        rd(ta(0, 0), 32'h06, "R11 ctrl0 untouched");
        rd(ta(0, 8), 32'd100, "R11 count0 untouched");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule